// File: doc/BRIEF.md
# Packed Float Uniform Vector Loader

This block sits on the register-write path of a shader front end. Software streams 32-bit words that hold floating-point constants. For each shader unit the block collects the words in a small staging store. When a full four-component vector has arrived, it turns the words into four 24-bit float components and writes them into that unit's 96-entry constant memory through a single-cycle write port.

There are two word formats, chosen by a mode bit. In float32 mode each of four words carries one IEEE single-precision value, which is narrowed to the 24-bit format. In packed mode three words carry the four 24-bit values bit for bit.

A destination index register, one per unit, selects the memory entry. The index is loaded directly and advances by one after each vector that is written. A completed vector whose index falls outside the memory is dropped and flagged with an error pulse. Each unit has its own counter, staging store and index, so streams aimed at different units never mix.

Top module: `fuv_loader`

## Requirements
- R1: A vector completes on a data write when the count of gathered words, including that write, reaches 4 with `fmt_f32`=1 or reaches 3 with `fmt_f32`=0. The mode bit used is the one present on that write. `mem_we` or `err` is high for exactly the one cycle after the clock edge that takes the completing write.
- R2: After a vector completes, the unit's word count returns to zero. The next write becomes word 0 of a new vector.
- R3: In float32 mode the first word received is converted into component w, the second into z, the third into y and the fourth into x. On `mem_data`, x sits in bits [23:0], y in [47:24], z in [71:48] and w in [95:72].
- R4: In packed mode the components are formed from the three gathered words as follows:
  - x = word2[23:0]
  - y = {word1[15:0], word2[31:24]}
  - z = {word0[7:0], word1[31:16]}
  - w = word0[31:8]
- R5: If the unit's index is 96 or more when a vector completes, `mem_we` stays low, `err` pulses for one cycle, and the index keeps its value.
- R6: After a vector is written to `mem_addr` = index, the index increases by one. Back-to-back vectors therefore land in consecutive entries, with `mem_unit` naming the unit.
- R7: Words and index loads apply only to the unit selected by `wr_unit`. A partial vector held by another unit is unaffected.
- R8: The float32-to-24-bit conversion works as follows:
  - The 24-bit format is {sign, 7-bit exponent with bias 63, 16-bit mantissa}.
  - When the float32 exponent e is 65 to 190, the result is {s, e-64, mantissa[22:7]}.
  - When e is 64 or less, the result is signed zero.
  - When e is 191 or more, the result is signed infinity {s, 7'h7f, 16'h0}.
- R9: `idx_load` sets the selected unit's index to `idx_value` and discards its partial vector. A data write to the same unit in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data word write strobe |
| wr_unit | input | 1 | Shader unit addressed by this cycle's write or load |
| wr_data | input | 32 | Data word |
| fmt_f32 | input | 1 | 1 = float32 words, 0 = packed 24-bit words |
| idx_load | input | 1 | Load the destination index and clear the partial vector |
| idx_value | input | 7 | Index value to load |
| mem_we | output | 1 | Constant memory write strobe |
| mem_unit | output | 1 | Unit whose memory is written |
| mem_addr | output | 7 | Entry being written |
| mem_data | output | 96 | Vector {w, z, y, x}, 24 bits each |
| err | output | 1 | A completed vector was dropped because its index was out of range |

## Verification
The bench targets four kinds of error:
- Index boundary at 95, 96 and values above it. A design with an off-by-one bound would write entry 96 or reject entry 95.
- Exponent boundaries around the conversion range (64/65 and 190/191), plus zero and all-ones exponents. Wrong bounds would produce a small denormal-like value where zero is expected, or a wrapped exponent where infinity is expected.
- Changing the mode in the middle of a vector, and an index load in the same cycle as a write. A design that latched the mode early, or let the write win, would complete one word early or late and shift every later vector.
- Words for the two units interleaved. If the staging state were shared, one unit's words would leak into the other unit's vector.

// File: rtl/fuv_pkg.sv
package fuv_pkg;

    localparam int WORD_W = 32;
    localparam int COMP_W = 24;
    localparam int NCOMP  = 4;
    localparam int VEC_W  = COMP_W * NCOMP;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [COMP_W-1:0] comp_t;
    typedef logic [NCOMP-1:0][WORD_W-1:0] words_t;

    // Narrow an IEEE single to {s, exp7 (bias 63), man16}: truncate, flush, saturate.
    function automatic comp_t f32_to_f24(input word_t f);
        logic [7:0] e;
        logic [7:0] r;
        e = f[30:23];
        r = e - 8'd64;
        if (e <= 8'd64) begin
            return {f[31], 23'd0};
        end else if (e >= 8'd191) begin
            return {f[31], 7'h7f, 16'd0};
        end else begin
            return {f[31], r[6:0], f[22:7]};
        end
    endfunction

endpackage

// File: rtl/fuv_gather.sv
module fuv_gather
    import fuv_pkg::*;
#(
    parameter int DEPTH  = 96,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              ld,
    input  logic              f32,
    input  word_t             din,
    input  logic [ADDR_W-1:0] idx_in,
    output logic              done,
    output logic              bad,
    output logic [ADDR_W-1:0] addr,
    output words_t            words
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    typedef struct packed {
        logic [1:0]        cnt;
        logic [ADDR_W-1:0] idx;
        words_t            stash;
    } gst_t;

    gst_t state_d, state_q;
    logic last;

    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        bad     = 1'b0;
        addr    = state_q.idx;
        for (int k = 0; k < NCOMP; k++) begin
            words[k] = (state_q.cnt == 2'(k)) ? din : state_q.stash[k];
        end
        last = f32 ? (state_q.cnt == 2'd3) : (state_q.cnt >= 2'd2);
        if (ld) begin
            state_d.cnt = 2'd0;
            state_d.idx = idx_in;
        end else if (wr) begin
            if (last) begin
                state_d.cnt = 2'd0;
                if ({1'b0, state_q.idx} < LIMIT) begin
                    done        = 1'b1;
                    state_d.idx = state_q.idx + 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end else begin
                state_d.stash[state_q.cnt] = din;
                state_d.cnt = state_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // A completed vector restarts the gather
    assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || bad) |=> state_q.cnt == 2'd0);
    // A successful vector advances the index by one
    assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> state_q.idx == $past(state_q.idx) + 1'b1);
    // A rejected vector leaves the index alone
    assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> state_q.idx == $past(state_q.idx));
    // An index load wins and clears the partial vector
    assert_load_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (state_q.cnt == 2'd0) && (state_q.idx == $past(idx_in)));

endmodule

// File: rtl/fuv_convert.sv
module fuv_convert
    import fuv_pkg::*;
(
    input  logic             f32,
    input  words_t           words,
    output logic [VEC_W-1:0] vec
);

    logic [VEC_W-1:0] vec_f32;
    logic [VEC_W-1:0] vec_pk;

    // Float32 words arrive w first: word k lands in component (3-k)
    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
        assign vec_f32[(NCOMP-1-k)*COMP_W +: COMP_W] = f32_to_f24(words[k]);
    end

    // The 96 packed bits read from word0 down to word2 are w, z, y, x
    assign vec_pk = {words[0], words[1], words[2]};

    assign vec = f32 ? vec_f32 : vec_pk;

endmodule

// File: rtl/fuv_loader.sv
module fuv_loader
    import fuv_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int DEPTH     = 96,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic [31:0]       wr_data,
    input  logic              fmt_f32,
    input  logic              idx_load,
    input  logic [ADDR_W-1:0] idx_value,
    output logic              mem_we,
    output logic [UNIT_W-1:0] mem_unit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [95:0]       mem_data,
    output logic              err
);

    typedef struct packed {
        logic              we;
        logic              err;
        logic [UNIT_W-1:0] unit;
        logic [ADDR_W-1:0] addr;
        logic [VEC_W-1:0]  data;
    } out_t;

    logic [NUM_UNITS-1:0]             u_done;
    logic [NUM_UNITS-1:0]             u_bad;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] u_addr;
    words_t                           u_words [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic sel;
        assign sel = (wr_unit == UNIT_W'(u));
        fuv_gather #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_gather (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_en && sel),
            .ld     (idx_load && sel),
            .f32    (fmt_f32),
            .din    (wr_data),
            .idx_in (idx_value),
            .done   (u_done[u]),
            .bad    (u_bad[u]),
            .addr   (u_addr[u]),
            .words  (u_words[u])
        );
    end

    words_t           sel_words;
    logic [VEC_W-1:0] sel_vec;
    out_t             out_d, out_q;

    always_comb begin
        sel_words = u_words[0];
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (wr_unit == UNIT_W'(u)) sel_words = u_words[u];
        end
    end

    fuv_convert u_convert (
        .f32   (fmt_f32),
        .words (sel_words),
        .vec   (sel_vec)
    );

    always_comb begin
        out_d      = '0;
        out_d.unit = wr_unit;
        out_d.data = sel_vec;
        out_d.we   = |u_done;
        out_d.err  = |u_bad;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (wr_unit == UNIT_W'(u)) out_d.addr = u_addr[u];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign mem_we   = out_q.we;
    assign err      = out_q.err;
    assign mem_unit = out_q.unit;
    assign mem_addr = out_q.addr;
    assign mem_data = out_q.data;

    // Only the addressed unit may finish a vector in a cycle
    assert_single_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(u_done | u_bad));
    // A write and an error never coincide
    assert_we_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && err));
    // No write ever reaches beyond the memory
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < (ADDR_W+1)'(DEPTH)));

endmodule

// File: tb/tb_fuv_loader.sv
module tb_fuv_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_unit = '0;
    logic [31:0] wr_data = '0;
    logic        fmt_f32 = 1'b0;
    logic        idx_load = 1'b0;
    logic [6:0]  idx_value = '0;
    logic        mem_we;
    logic [0:0]  mem_unit;
    logic [6:0]  mem_addr;
    logic [95:0] mem_data;
    logic        err;

    int tests = 0;
    int fails = 0;

    int          m_cnt [2];
    int          m_idx [2];
    logic [31:0] m_buf [2][4];

    always #5 clk = ~clk;

    fuv_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit),
        .wr_data(wr_data), .fmt_f32(fmt_f32), .idx_load(idx_load),
        .idx_value(idx_value), .mem_we(mem_we), .mem_unit(mem_unit),
        .mem_addr(mem_addr), .mem_data(mem_data), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R8 conversion rule
    function automatic logic [23:0] cvt(input logic [31:0] f);
        int e;
        e = int'(f[30:23]);
        if (e <= 64) return {f[31], 23'd0};
        if (e >= 191) return {f[31], 7'h7f, 16'd0};
        return {f[31], 7'(e - 64), f[22:7]};
    endfunction

    // R3 / R4 vector assembly
    function automatic logic [95:0] expect_vec(input bit f32, input logic [31:0] a, input logic [31:0] b,
                                               input logic [31:0] c, input logic [31:0] d);
        if (f32) return {cvt(a), cvt(b), cvt(c), cvt(d)};
        return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
    endfunction

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int u, input bit f32, input logic [31:0] d, input string req);
        bit fin;
        bit ok_idx;
        logic [95:0] ev;
        m_buf[u][m_cnt[u]] = d;
        fin = (m_cnt[u] + 1) >= (f32 ? 4 : 3);
        ok_idx = m_idx[u] < 96;
        ev = expect_vec(f32, m_buf[u][0], m_buf[u][1], m_buf[u][2], m_buf[u][3]);
        wr_en = 1'b1; wr_unit = 1'(u); wr_data = d; fmt_f32 = f32;
        step();
        wr_en = 1'b0;
        check(mem_we == (fin && ok_idx), {req, " R1 mem_we"}, 96'(mem_we), 96'(fin && ok_idx));
        check(err == (fin && !ok_idx), {req, " R5 err"}, 96'(err), 96'(fin && !ok_idx));
        if (fin && ok_idx) begin
            check(mem_addr == 7'(m_idx[u]) && mem_unit == 1'(u), {req, " R6 addr/unit"},
                  96'({mem_unit, mem_addr}), 96'({1'(u), 7'(m_idx[u])}));
            check(mem_data == ev, {req, f32 ? " R3 data" : " R4 data"}, mem_data, ev);
            m_idx[u]++;
        end
        if (fin) m_cnt[u] = 0;
        else m_cnt[u]++;
    endtask

    task automatic ld(input int u, input int v, input bit with_wr);
        idx_load = 1'b1; wr_unit = 1'(u); idx_value = 7'(v);
        wr_en = with_wr; wr_data = 32'hdead_beef;
        step();
        idx_load = 1'b0; wr_en = 1'b0;
        check(!mem_we && !err, "R9 load produces no output", 96'({mem_we, err}), 96'(0));
        m_cnt[u] = 0;
        m_idx[u] = v;
    endtask

    function automatic logic [31:0] fmk(input bit s, input int e, input logic [22:0] m);
        return {s, 8'(e), m};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int u = 0; u < 2; u++) begin m_cnt[u] = 0; m_idx[u] = 0; end
        repeat (2) @(negedge clk);
        check(!mem_we && !err, "reset R1 outputs idle", 96'({mem_we, err}), 96'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 float32 order and R8 regular conversion
        wr(0, 1, 32'h3f80_0000, "f32 v0");
        wr(0, 1, 32'h4000_0000, "f32 v0");
        wr(0, 1, 32'hc040_0000, "f32 v0");
        wr(0, 1, 32'h3f00_1234, "f32 v0");
        // R4 packed layout, R2 restart, R6 increments
        wr(0, 0, 32'h1122_3344, "pk v1");
        wr(0, 0, 32'h5566_7788, "pk v1");
        wr(0, 0, 32'h99aa_bbcc, "pk v1");
        // R8 exponent corners
        wr(0, 1, fmk(1, 64, 23'h7fffff), "R8 e64 zero");
        wr(0, 1, fmk(0, 65, 23'h400001), "R8 e65");
        wr(0, 1, fmk(1, 190, 23'h12345), "R8 e190");
        wr(0, 1, fmk(0, 191, 23'h0), "R8 e191 inf");
        wr(0, 1, fmk(1, 0, 23'h1), "R8 e0");
        wr(0, 1, fmk(0, 255, 23'h1), "R8 e255");
        wr(0, 1, fmk(0, 127, 23'h0), "R8");
        wr(0, 1, fmk(0, 128, 23'h0), "R8");
        // R5 boundary at 95 / 96
        ld(0, 95, 0);
        for (int k = 0; k < 3; k++) wr(0, 0, $urandom, "R5 idx95");
        for (int k = 0; k < 3; k++) wr(0, 0, $urandom, "R5 idx96");
        ld(0, 120, 0);
        for (int k = 0; k < 4; k++) wr(0, 1, $urandom, "R5 idx120");
        // R9 load discards partial and wins over same-cycle write
        ld(0, 10, 0);
        wr(0, 0, $urandom, "R9 partial");
        ld(0, 20, 1);
        for (int k = 0; k < 3; k++) wr(0, 0, $urandom, "R9 after load");
        // R1 mode change mid-vector: three f32 words, then packed completes at once
        for (int k = 0; k < 3; k++) wr(1, 1, $urandom, "R1 mode switch");
        wr(1, 0, 32'h0123_4567, "R1 mode switch");
        // R7 interleaved units
        ld(1, 40, 0);
        for (int k = 0; k < 4; k++) begin
            wr(0, 0, $urandom, "R7 interleave u0");
            wr(1, 1, $urandom, "R7 interleave u1");
        end
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int u;
            int r;
            u = int'($urandom_range(1, 0));
            r = int'($urandom_range(99, 0));
            if (r < 4) begin
                ld(u, int'($urandom_range(100, 0)), r[0]);
            end else begin
                bit f;
                int e;
                f = (r < 55);
                e = int'($urandom_range(255, 0));
                wr(u, f, f ? fmk(1'($urandom), e, 23'($urandom)) : $urandom, "R1 random");
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule